// File: doc/BRIEF.md
# Fractional Sample Strobe Generator

This block derives a slow, evenly spread sample strobe from a fast reference clock that has no integer relation to the wanted rate. A single 32-bit configuration word holds a numerator N and a stored denominator field. The block emits one-cycle pulses whose long-run spacing is N divided by the denominator, in reference cycles. The denominator is the stored field plus one. Software picks the pair as the closest rational fit of reference frequency over sample rate. An audio sample clock can then be produced without a PLL.

Internally a phase accumulator grows by the denominator every cycle. When it reaches N, a pulse is issued and N is taken back off. The pulse pattern therefore spreads the rounding error evenly, and no two successive gaps differ by more than one cycle. Writing the configuration word restarts the phase from zero. A zero numerator parks the output low.

Top module: `frac_strobe_gen`

## Requirements
- R1: Synchronous active-high reset clears the numerator and denominator field to zero, clears the phase, and holds `strobe_o` low; after reset and before any write, no pulse appears.
- R2: A write with `cfg_we` high loads N from `cfg_wdata[31:8]` and the denominator field from `cfg_wdata[7:0]`; the step added per cycle is the field value plus one, so the step spans 1 to 256.
- R3: Counting k clock edges after the write edge, `strobe_o` is high after edge k exactly when floor(k*D/N) differs from floor((k-1)*D/N), where D is the step; this holds whenever N is non-zero.
- R4: Over any run of k cycles after a write, the number of pulses equals floor(k*D/N), so the mean spacing tends to N/D cycles.
- R5: The write edge clears the phase: `strobe_o` is low on the cycle after the write, even if pulses were being produced, and the pattern then restarts per R3.
- R6: While N is zero, `strobe_o` stays low.
- R7: When N is non-zero and N is not larger than D, `strobe_o` is high on every cycle after the write edge.
- R8: Between writes, the gaps between consecutive pulses differ from each other by at most one cycle.
- R9: The phase accumulator is one bit wider than N and never exceeds N plus 256; when N is greater than D, it stays below N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | One-cycle write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: N in the upper 24 bits, denominator minus one in the lower 8 |
| strobe_o | output | 1 | Registered one-cycle sample strobe |

## Verification
The assertions take for granted that reset is held high from time zero over at least one clock edge. They also assume the configuration only changes through `cfg_we`, so every check between writes sees a fixed N and step. The stimulus raises reset at the start of the run and again in the middle. It issues each write as a single-cycle `cfg_we` pulse and picks ratios whose gaps are short enough for several gap pairs to fall inside each phase. The phases span both the saturated case (N not above D) and the ordinary case (N above D).

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int unsigned FSG_N_W = 24;
  localparam int unsigned FSG_M_W = 8;

  typedef enum logic [1:0] {
    STEP_IDLE  = 2'd0,
    STEP_ACCUM = 2'd1,
    STEP_WRAP  = 2'd2,
    STEP_SAT   = 2'd3
  } step_e;
endpackage

// File: rtl/frac_cfg_reg.sv
module frac_cfg_reg #(
  parameter int unsigned N_W = fsg_pkg::FSG_N_W,
  parameter int unsigned M_W = fsg_pkg::FSG_M_W,
  localparam int unsigned REG_W = N_W + M_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [N_W-1:0]   n_o,
  output logic [M_W:0]     inc_o
);
  logic [N_W-1:0] n_q;
  logic [M_W-1:0] m_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q <= '0;
      m_q <= '0;
    end else if (we) begin
      n_q <= wdata[REG_W-1:M_W];
      m_q <= wdata[M_W-1:0];
    end
  end

  assign n_o   = n_q;
  assign inc_o = {1'b0, m_q} + {{M_W{1'b0}}, 1'b1};
endmodule

// File: rtl/frac_step.sv
module frac_step #(
  parameter int unsigned N_W = fsg_pkg::FSG_N_W,
  parameter int unsigned M_W = fsg_pkg::FSG_M_W,
  localparam int unsigned ACC_W = N_W + 1
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [N_W-1:0]   n_i,
  input  logic [M_W:0]     inc_i,
  output logic [ACC_W-1:0] acc_next_o,
  output logic             hit_o
);
  import fsg_pkg::*;

  logic [ACC_W-1:0] n_ext;
  logic [ACC_W-1:0] inc_ext;
  logic [ACC_W-1:0] sum;
  step_e            kind;

  always_comb begin
    n_ext   = {1'b0, n_i};
    inc_ext = ACC_W'(inc_i);
    sum     = acc_i + inc_ext;
    if (n_i == '0)             kind = STEP_IDLE;
    else if (n_ext <= inc_ext) kind = STEP_SAT;
    else if (sum >= n_ext)     kind = STEP_WRAP;
    else                       kind = STEP_ACCUM;
  end

  always_comb begin
    unique case (kind)
      STEP_IDLE: begin
        acc_next_o = '0;
        hit_o      = 1'b0;
      end
      STEP_SAT: begin
        acc_next_o = '0;
        hit_o      = 1'b1;
      end
      STEP_WRAP: begin
        acc_next_o = sum - n_ext;
        hit_o      = 1'b1;
      end
      default: begin
        acc_next_o = sum;
        hit_o      = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/frac_phase_reg.sv
module frac_phase_reg #(
  parameter int unsigned N_W = fsg_pkg::FSG_N_W,
  parameter int unsigned M_W = fsg_pkg::FSG_M_W,
  localparam int unsigned ACC_W = N_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [ACC_W-1:0] acc_next_i,
  input  logic             hit_i,
  input  logic [N_W-1:0]   n_i,
  input  logic [M_W:0]     inc_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             strobe_o
);
  logic [ACC_W-1:0] acc_q;
  logic             strobe_q;

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      acc_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      acc_q    <= acc_next_i;
      strobe_q <= hit_i;
    end
  end

  assign acc_o    = acc_q;
  assign strobe_o = strobe_q;

  // Gap tracking used only by the spacing check below.
  logic [ACC_W-1:0] gap_q;
  logic [ACC_W-1:0] prev_gap_q;
  logic [1:0]       seen_q;

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      gap_q      <= '0;
      prev_gap_q <= '0;
      seen_q     <= '0;
    end else if (strobe_q) begin
      gap_q      <= {{(ACC_W-1){1'b0}}, 1'b1};
      prev_gap_q <= gap_q;
      if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
    end else begin
      gap_q <= gap_q + {{(ACC_W-1){1'b0}}, 1'b1};
    end
  end

  // R9
  acc_below_n_chk: assert property (@(posedge clk) disable iff (rst)
    ((n_i != '0) && ({1'b0, n_i} > ACC_W'(inc_i))) |-> (acc_q < {1'b0, n_i}));

  // R5
  load_clear_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> ((acc_q == '0) && !strobe_q));

  // R6
  zero_n_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && (n_i == '0)) |=> !strobe_q);

  // R7
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && (n_i != '0) && ({1'b0, n_i} <= ACC_W'(inc_i))) |=> strobe_q);

  // R8
  gap_spread_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_q && (seen_q == 2'd2)) |->
      ((gap_q <= prev_gap_q + 1'b1) && (prev_gap_q <= gap_q + 1'b1)));
endmodule

// File: rtl/frac_strobe_gen.sv
module frac_strobe_gen #(
  parameter int unsigned N_W = fsg_pkg::FSG_N_W,
  parameter int unsigned M_W = fsg_pkg::FSG_M_W,
  localparam int unsigned REG_W = N_W + M_W,
  localparam int unsigned ACC_W = N_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic             strobe_o
);
  logic [N_W-1:0]   n_w;
  logic [M_W:0]     inc_w;
  logic [ACC_W-1:0] acc_w;
  logic [ACC_W-1:0] acc_next_w;
  logic             hit_w;

  frac_cfg_reg #(.N_W(N_W), .M_W(M_W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .n_o   (n_w),
    .inc_o (inc_w)
  );

  frac_step #(.N_W(N_W), .M_W(M_W)) u_step (
    .acc_i      (acc_w),
    .n_i        (n_w),
    .inc_i      (inc_w),
    .acc_next_o (acc_next_w),
    .hit_o      (hit_w)
  );

  frac_phase_reg #(.N_W(N_W), .M_W(M_W)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .load_i     (cfg_we),
    .acc_next_i (acc_next_w),
    .hit_i      (hit_w),
    .n_i        (n_w),
    .inc_i      (inc_w),
    .acc_o      (acc_w),
    .strobe_o   (strobe_o)
  );

  // R9
  acc_headroom_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_w <= ({1'b0, n_w} + ACC_W'(256))));
endmodule

// File: tb/frac_strobe_gen_test.sv
module frac_strobe_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        strobe_o;

  int n_checks = 0;
  int n_fail   = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  frac_strobe_gen uut (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .strobe_o  (strobe_o)
  );

  // Behavioural reference: pulse count after k cycles is floor(k*D/N).
  longint mdl_n = 0;
  longint mdl_d = 1;
  longint mdl_k = 0;
  bit     exp_strobe = 1'b0;
  bit     track_clear = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      mdl_n = 0; mdl_d = 1; mdl_k = 0; exp_strobe = 1'b0; track_clear = 1'b1;
    end else if (cfg_we) begin
      mdl_n = longint'(cfg_wdata[31:8]);
      mdl_d = longint'(cfg_wdata[7:0]) + 1;
      mdl_k = 0; exp_strobe = 1'b0; track_clear = 1'b1;
    end else begin
      mdl_k = mdl_k + 1;
      if (mdl_n == 0) exp_strobe = 1'b0;
      else exp_strobe = ((mdl_k * mdl_d) / mdl_n) != (((mdl_k - 1) * mdl_d) / mdl_n);
    end
  end

  longint cyc = 0;
  longint last_cyc = 0;
  longint prev_iv = 0;
  longint win = 0;
  bit have_last = 1'b0;
  bit have_iv = 1'b0;

  always @(posedge clk) begin
    #2;
    cyc = cyc + 1;
    n_checks++;
    if (strobe_o !== exp_strobe) begin
      n_fail++;
      $display("FAIL %s: strobe_o actual %0b expected %0b (cycle %0d)", tag, strobe_o, exp_strobe, cyc);
    end
    if (track_clear) begin
      have_last = 1'b0; have_iv = 1'b0; win = 0; track_clear = 1'b0;
    end
    if (strobe_o === 1'b1) begin
      win = win + 1;
      if (have_last) begin
        longint iv;
        iv = cyc - last_cyc;
        if (have_iv) begin
          n_checks++;
          if (iv > prev_iv + 1 || prev_iv > iv + 1) begin
            n_fail++;
            $display("FAIL R8: gap actual %0d expected within 1 of %0d", iv, prev_iv);
          end
        end
        prev_iv = iv;
        have_iv = 1'b1;
      end
      last_cyc = cyc;
      have_last = 1'b1;
    end
  end

  task automatic write_cfg(input logic [23:0] n, input logic [7:0] m);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = {n, m};
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic run(input int c);
    repeat (c) @(posedge clk);
    #3;
  endtask

  task automatic check_count(input string t, input longint expv);
    n_checks++;
    if (win != expv) begin
      n_fail++;
      $display("FAIL %s: pulse count actual %0d expected %0d", t, win, expv);
    end
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    run(6);
    check_count("R1", 0);

    tag = "R3"; write_cfg(24'd7, 8'd2); run(40);
    check_count("R3", (40 * 3) / 7);

    tag = "R4"; write_cfg(24'd100, 8'd15); run(200);
    check_count("R4", (200 * 16) / 100);

    tag = "R2"; @(posedge clk); #1; cfg_we = 1'b1; cfg_wdata = 32'h0000_0A04;
    @(posedge clk); #1; cfg_we = 1'b0; run(20);
    check_count("R2", (20 * 5) / 10);

    tag = "R2"; write_cfg(24'd1000, 8'd255); run(100);
    check_count("R2", (100 * 256) / 1000);

    tag = "R2"; write_cfg(24'hFFFFFF, 8'd0); run(50);
    check_count("R2", 0);

    tag = "R6"; write_cfg(24'd0, 8'd5); run(20);
    check_count("R6", 0);

    tag = "R7"; write_cfg(24'd3, 8'd7); run(10);
    check_count("R7", 10);

    tag = "R5"; write_cfg(24'd4, 8'd1); run(12);
    check_count("R5", (12 * 2) / 4);

    tag = "R7"; write_cfg(24'd5, 8'd4); run(5);
    check_count("R7", 5);

    tag = "R8"; write_cfg(24'd17, 8'd4); run(60);
    check_count("R8", (60 * 5) / 17);

    tag = "R5"; write_cfg(24'd7, 8'd2); run(11);
    write_cfg(24'd9, 8'd3); run(30);
    check_count("R5", (30 * 4) / 9);

    tag = "R1"; @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk); #1 rst = 1'b0;
    run(8);
    check_count("R1", 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1: watchdog actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule